// File: doc/BRIEF.md
# Triplicated Majority-Voted Adder Stage

This block is one registered pipeline stage built three times over. Each of the three lanes has its own operand inputs, its own adder, its own result register and its own bitwise two-out-of-three voter. Every voter reads all three lane registers, and each lane's voter drives that lane's output, so the next stage also receives three independent copies. No single register, adder or voter decides the result for everyone. A per-bit disagreement vector shows where the three registers currently differ.

One clock and one synchronous active-high reset serve all three lanes; clock redundancy is not part of this stage. For testing, each lane has a one-cycle injection strobe and a mask. While a strobe is high, the next clock edge loads that lane's register with the sum XOR the mask. The stage takes new operands every cycle and has no back-pressure: there is no valid/ready handshake, and a result appears on the outputs one clock edge after its operands are sampled.

Top module: `tmr_voted_stage`

## Requirements
- R1: While `rst` is high at a clock edge, all three lane registers load zero, so every `res_o` lane and `disagree_o` read zero after that edge.
- R2: With no injection and identical operands in all lanes, every `res_o` lane equals `(opa + opb) mod 2^W` one clock edge after the operands are sampled, including carry-out wrap.
- R3: Each output bit is the two-out-of-three majority of the three lane register bits: zero or one ones give 0, two or three ones give 1.
- R4: An injection into exactly one lane (`inj_en_i` has one bit set, bit c selects lane c) flips that lane's register bits where the mask is 1, and all three outputs still equal the fault-free sum.
- R5: Bit i of `disagree_o` is 1 exactly when the three lane registers do not all hold the same value at bit i.
- R6: A flipped lane register takes the fault-free value again at the first edge without injection, and `disagree_o` returns to zero.
- R7: The three `res_o` lanes carry the same value in every cycle.
- R8: Reset takes priority over injection: with `rst` high, set injection strobes leave all registers at zero.
- R9: If two lanes receive the same mask in the same cycle, the outputs show the sum XOR that mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset for all lanes |
| opa_i | input | 3 x W | First operand, one W-bit word per lane |
| opb_i | input | 3 x W | Second operand, one W-bit word per lane |
| inj_en_i | input | 3 | One-cycle injection strobe per lane |
| inj_mask_i | input | 3 x W | Bits to flip in each lane's register |
| res_o | output | 3 x W | Voted result, one copy per lane |
| disagree_o | output | W | Per-bit lane mismatch flag |

## Verification
Masking and mismatch reporting happen in the same cycle: the edge that corrupts a lane must leave the voted result clean while `disagree_o` lights exactly the corrupted bits. The bench provokes this by injecting into one or two lanes together with fresh operands. It judges both outputs on that cycle against a reference that builds the three lane values, votes them bit by bit and ORs their pairwise differences. Operand tables with lane-specific words, including three mutually different lanes, exercise the voter where no two lanes agree on the whole word.

// File: rtl/tmr_stage_pkg.sv
package tmr_stage_pkg;
  localparam int unsigned NLANE = 3;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/tmr_copy_lane.sv
module tmr_copy_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         inj_en,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] sum_w;
  logic [W-1:0] flip_w;

  always_comb begin
    sum_w  = opa + opb;
    flip_w = inj_en ? inj_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sum_w ^ flip_w;
  end
endmodule

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter
  import tmr_stage_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = maj3(a[i], b[i], c[i]);
  end

  always_comb begin
    if (a == b) p_unanimous_pair_r3: assert (y == a);
    if (a == c) p_unanimous_pair2_r3: assert (y == a);
  end
endmodule

// File: rtl/tmr_mismatch.sv
module tmr_mismatch #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] diff
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = (a[i] ^ b[i]) | (b[i] ^ c[i]);
  end
endmodule

// File: rtl/tmr_voted_stage.sv
module tmr_voted_stage
  import tmr_stage_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NLANE-1:0][W-1:0] opa_i,
  input  logic [NLANE-1:0][W-1:0] opb_i,
  input  logic [NLANE-1:0]      inj_en_i,
  input  logic [NLANE-1:0][W-1:0] inj_mask_i,
  output logic [NLANE-1:0][W-1:0] res_o,
  output logic [W-1:0]          disagree_o
);
  logic [NLANE-1:0][W-1:0] lane_q;
  logic                    ops_uniform;

  for (genvar c = 0; c < NLANE; c++) begin : g_lane
    tmr_copy_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .opa      (opa_i[c]),
      .opb      (opb_i[c]),
      .inj_en   (inj_en_i[c]),
      .inj_mask (inj_mask_i[c]),
      .q        (lane_q[c])
    );
    tmr_maj_voter #(.W(W)) u_vote (
      .a (lane_q[0]),
      .b (lane_q[1]),
      .c (lane_q[2]),
      .y (res_o[c])
    );
  end

  tmr_mismatch #(.W(W)) u_mis (
    .a    (lane_q[0]),
    .b    (lane_q[1]),
    .c    (lane_q[2]),
    .diff (disagree_o)
  );

  assign ops_uniform = (opa_i[0] == opa_i[1]) && (opa_i[1] == opa_i[2]) &&
                       (opb_i[0] == opb_i[1]) && (opb_i[1] == opb_i[2]);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && disagree_o == '0));

  p_lanes_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (res_o[0] == res_o[1]) && (res_o[1] == res_o[2]));

  p_single_fault_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops_uniform) && $onehot0($past(inj_en_i)))
      |-> (res_o[0] == W'($past(opa_i[0]) + $past(opb_i[0]))));

  p_quiet_no_disagree_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops_uniform) && $past(inj_en_i) == '0)
      |-> (disagree_o == '0));
endmodule

// File: tb/test_tmr_voted_stage.sv
`timescale 1ns/1ps
module test_tmr_voted_stage;
  localparam int unsigned W = 8;
  localparam int NV = 8;
  localparam logic [W-1:0] TA  [NV] = '{8'h03, 8'hFF, 8'hFF, 8'h5A, 8'h12, 8'h80, 8'h0F, 8'h7F};
  localparam logic [W-1:0] TB  [NV] = '{8'h04, 8'h01, 8'hFF, 8'hA5, 8'h34, 8'h80, 8'h01, 8'h01};
  localparam logic [2:0]   TEN [NV] = '{3'b000, 3'b000, 3'b000, 3'b001, 3'b100, 3'b010, 3'b011, 3'b101};
  localparam logic [W-1:0] TMK [NV] = '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h81, 8'h01, 8'h10, 8'hFF};

  logic clk = 0;
  logic rst = 1;
  logic [2:0][W-1:0] opa_i, opb_i, inj_mask_i;
  logic [2:0] inj_en_i;
  logic [2:0][W-1:0] res_o;
  logic [W-1:0] disagree_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_voted_stage #(.W(W)) i_tmr_voted_stage (
    .clk(clk), .rst(rst), .opa_i(opa_i), .opb_i(opb_i),
    .inj_en_i(inj_en_i), .inj_mask_i(inj_mask_i),
    .res_o(res_o), .disagree_o(disagree_o)
  );

  function automatic logic [W-1:0] vote(input logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp_r, input logic [W-1:0] exp_d);
    for (int c = 0; c < 3; c++) begin
      n_cmp++;
      if (res_o[c] !== exp_r) begin
        n_bad++;
        $display("FAIL %s res_o[%0d] actual %h expected %h", tag, c, res_o[c], exp_r);
      end
    end
    n_cmp++;
    if (disagree_o !== exp_d) begin
      n_bad++;
      $display("FAIL %s disagree_o actual %h expected %h", tag, disagree_o, exp_d);
    end
  endtask

  // drive at negedge, let one edge load, sample 1 ns after it
  task automatic step(input logic [2:0][W-1:0] a, b, input logic [2:0] en,
                      input logic [W-1:0] mask);
    @(negedge clk);
    opa_i = a; opb_i = b; inj_en_i = en;
    for (int c = 0; c < 3; c++) inj_mask_i[c] = mask;
    @(posedge clk); #1;
    inj_en_i = '0;
  endtask

  task automatic expect_lanes(input string tag, input logic [W-1:0] l0, l1, l2);
    check(tag, vote(l0, l1, l2), (l0 ^ l1) | (l1 ^ l2));
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] s;
    logic [W-1:0] l [3];
    string tag;
    opa_i = '0; opb_i = '0; inj_en_i = '0; inj_mask_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0, '0);

    // R8: reset wins over injection in every lane
    step({3{8'h11}}, {3{8'h22}}, 3'b111, 8'hFF);
    check("R8", '0, '0);
    @(negedge clk); rst = 0;

    // table walk: R2 clean, R4 single lane, R9 two lanes; R3 and R5 judged in every row
    for (int v = 0; v < NV; v++) begin
      step({3{TA[v]}}, {3{TB[v]}}, TEN[v], TMK[v]);
      s = TA[v] + TB[v];
      for (int c = 0; c < 3; c++) l[c] = s ^ (TEN[v][c] ? TMK[v] : '0);
      tag = (TEN[v] == 0) ? "R2" : (($countones(TEN[v]) == 1) ? "R4" : "R9");
      expect_lanes(tag, l[0], l[1], l[2]);
    end

    // R6: recovery after fault at the next clean edge
    step({3{8'h40}}, {3{8'h02}}, 3'b010, 8'hF0);
    expect_lanes("R4", 8'h42, 8'hB2, 8'h42);
    step({3{8'h40}}, {3{8'h02}}, 3'b000, 8'h00);
    check("R6", 8'h42, 8'h00);

    // R3/R5: lane-specific operands, one lane off
    step({8'h10, 8'h22, 8'h10}, {8'h01, 8'h00, 8'h01}, 3'b000, 8'h00);
    check("R3", 8'h11, 8'h33);
    // R3/R5: all three lanes different
    step({8'h3C, 8'hF0, 8'h0F}, {8'h00, 8'h00, 8'h00}, 3'b000, 8'h00);
    check("R5", 8'h3C, 8'hFF);

    // R1 again mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R1", '0, '0);
    @(negedge clk); rst = 0;
    step({3{8'hFE}}, {3{8'h03}}, 3'b000, 8'h00);
    check("R2", 8'h01, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule